// File: doc/BRIEF.md
# CAN Receive Acceptance Filter

This block decides, for each received CAN frame, whether the frame is kept. A frame decoder presents the frame header (format flag, remote flag, identifier, data length and the first two data bytes) with a one-cycle strobe. One cycle later the block returns a keep/drop verdict. The verdict comes from comparing the header against four 8-bit code bytes under four 8-bit mask bytes.

A mode bit selects between one wide filter and two narrower filters. Standard and extended frames lay their fields out differently across the code bytes. Standard frames can also be filtered on data bits. A mask bit of 1 turns the matching code bit into a don't-care.

The code, mask and mode settings can only change while the controller is held in its reset (configuration) mode. Writes at any other time are dropped, so a frame never sees a half-written filter.

Top module: `can_accept_filter`

## Requirements
- R1: After reset all code bytes are 0x00, all mask bytes are 0xFF and dual mode is selected, so every frame is accepted; `accept_vld` is low during reset.
- R2: `accept_vld` is high for exactly the one cycle after a cycle with `frm_valid` high, and low otherwise; `accept` holds the verdict of the latest strobed frame.
- R3: A mask bit of 1 makes the code bit at the same position a don't-care. A compared bit whose mask is 0 and whose value differs from the code rejects the filter.
- R4: Configuration writes take effect only when `ctl_reset_mode` is 1 and are ignored otherwise. The selector values are: 0..3 for code bytes 0..3, 4..7 for mask bytes 0..3, and 8 for the mode bit (wdata bit 0; 1 = single filter, 0 = dual filter).
- R5: In single mode, a standard frame is compared as follows: byte0 against ID[10:3]; byte1 bits 7:5 against ID[2:0] and bit 4 against RTR; byte2 against data byte 0; byte3 against data byte 1.
- R6: In single mode, an extended frame is compared as follows: bytes 0..2 against ID[28:21], ID[20:13] and ID[12:5]; byte3 bits 7:3 against ID[4:0] and bit 2 against RTR.
- R7: In dual mode with a standard frame, filter A compares byte0 and byte1 bits 7:4 as ID[10:3], ID[2:0] and RTR, and byte1 bits 3:0 against data byte 0 bits 7:4. Filter B compares byte2 and byte3 bits 7:4 as ID[10:3], ID[2:0] and RTR.
- R8: In dual mode with an extended frame, filter A compares ID[28:13] with {byte0, byte1} and filter B compares ID[28:13] with {byte2, byte3}.
- R9: In dual mode a frame is accepted when filter A or filter B matches.
- R10: A data-byte comparison counts as a match when the frame is a remote frame or its DLC does not cover that byte. Data byte 0 needs DLC at least 1, and data byte 1 needs DLC at least 2.
- R11: Code bits no field uses are don't-care whatever their mask. These are byte1 bits 3:0 (single, standard), byte3 bits 1:0 (single, extended) and byte3 bits 3:0 (dual, standard).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_reset_mode | input | 1 | Controller is in configuration (reset) mode |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | Configuration target selector |
| cfg_wdata | input | 8 | Configuration write data |
| frm_valid | input | 1 | One-cycle strobe: header fields are valid |
| frm_ext | input | 1 | 1 = extended (29-bit) identifier |
| frm_rtr | input | 1 | 1 = remote frame |
| frm_id | input | 29 | Identifier, right aligned (standard uses bits 10:0) |
| frm_dlc | input | 4 | Data length code |
| frm_data0 | input | 8 | First data byte |
| frm_data1 | input | 8 | Second data byte |
| accept_vld | output | 1 | Verdict valid, one cycle after `frm_valid` |
| accept | output | 1 | 1 = keep the frame |

## Verification
The bench builds the block with its default parameters: 8-bit code and mask bytes, four of each, a 4-bit selector, and masks that reset open. With these values the byte layouts match the standard and extended frame formats exactly. That puts every field position, every unused-bit case and every DLC cut-off within reach of directed frames. The tests also flip single identifier and data bits next to a byte boundary, which catches layouts shifted by one.

// File: rtl/can_accept_filter_pkg.sv
package can_accept_filter_pkg;
    localparam int EXT_ID_W = 29;
    localparam int STD_ID_W = 11;
    localparam int DLC_W    = 4;
    typedef enum logic {
        FILT_DUAL   = 1'b0,
        FILT_SINGLE = 1'b1
    } filt_mode_e;
endpackage

// File: rtl/canaf_cfg_regs.sv
// Holds the code bytes, mask bytes and mode bit.
// Assumes the selector map: codes at 0..NREG-1, masks at NREG..2*NREG-1,
// mode at 2*NREG. Byte 0 lands in the most significant byte of each vector.
module canaf_cfg_regs #(
    parameter int BYTE_W = 8,
    parameter int NREG   = 4,
    parameter int SEL_W  = 4,
    parameter logic [BYTE_W-1:0] MASK_INIT = '1,
    localparam int VEC_W = BYTE_W * NREG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_reset_mode,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [BYTE_W-1:0] cfg_wdata,
    output logic [VEC_W-1:0]  code_vec,
    output logic [VEC_W-1:0]  mask_vec,
    output logic              single_mode
);
    logic wr_ok;
    assign wr_ok = cfg_we && ctl_reset_mode;

    for (genvar i = 0; i < NREG; i++) begin : g_byte
        logic [BYTE_W-1:0] code_q, mask_q;
        // code byte i: cleared on reset, loaded by an allowed write
        always_ff @(posedge clk) begin
            if (!rst_n)                                code_q <= '0;
            else if (wr_ok && cfg_sel == SEL_W'(i))    code_q <= cfg_wdata;
        end
        // mask byte i: opens on reset, loaded by an allowed write
        always_ff @(posedge clk) begin
            if (!rst_n)                                     mask_q <= MASK_INIT;
            else if (wr_ok && cfg_sel == SEL_W'(NREG + i))  mask_q <= cfg_wdata;
        end
        assign code_vec[(NREG-1-i)*BYTE_W +: BYTE_W] = code_q;
        assign mask_vec[(NREG-1-i)*BYTE_W +: BYTE_W] = mask_q;
    end

    // mode bit: dual after reset, bit 0 of an allowed write
    always_ff @(posedge clk) begin
        if (!rst_n)                                       single_mode <= 1'b0;
        else if (wr_ok && cfg_sel == SEL_W'(2 * NREG))    single_mode <= cfg_wdata[0];
    end

    assert_cfg_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_reset_mode |=> ($stable(code_vec) && $stable(mask_vec) && $stable(single_mode)));
endmodule

// File: rtl/canaf_layout.sv
// Maps frame header fields onto the code-byte positions for every layout.
// Also marks the bits to ignore: unused positions, and data bytes that a
// remote frame or a short DLC does not carry.
// Assumes four 8-bit code bytes (the frame formats fix these widths).
module canaf_layout
    import can_accept_filter_pkg::*;
(
    input  logic                frm_ext,
    input  logic                frm_rtr,
    input  logic [EXT_ID_W-1:0] frm_id,
    input  logic [DLC_W-1:0]    frm_dlc,
    input  logic [7:0]          frm_data0,
    input  logic [7:0]          frm_data1,
    output logic [31:0]         one_field,
    output logic [31:0]         one_ign,
    output logic [15:0]         a_field,
    output logic [15:0]         a_ign,
    output logic [15:0]         b_field,
    output logic [15:0]         b_ign
);
    logic [STD_ID_W-1:0] sid;
    logic skip0, skip1;
    assign sid   = frm_id[STD_ID_W-1:0];
    assign skip0 = frm_rtr || (frm_dlc == '0);
    assign skip1 = frm_rtr || (frm_dlc < DLC_W'(2));

    // single-filter field image and ignore set
    always_comb begin
        if (frm_ext) begin
            one_field = {frm_id[28:5], frm_id[4:0], frm_rtr, 2'b00};
            one_ign   = {30'h0, 2'b11};
        end else begin
            one_field = {sid[10:3], sid[2:0], frm_rtr, 4'h0, frm_data0, frm_data1};
            one_ign   = {12'h000, 4'hF, {8{skip0}}, {8{skip1}}};
        end
    end

    // dual-filter images: both filters see the same header fields
    always_comb begin
        if (frm_ext) begin
            a_field = frm_id[28:13];
            a_ign   = 16'h0000;
            b_field = frm_id[28:13];
            b_ign   = 16'h0000;
        end else begin
            a_field = {sid[10:3], sid[2:0], frm_rtr, frm_data0[7:4]};
            a_ign   = {12'h000, {4{skip0}}};
            b_field = {sid[10:3], sid[2:0], frm_rtr, 4'h0};
            b_ign   = 16'h000F;
        end
    end
endmodule

// File: rtl/canaf_match.sv
// Masked equality: hit when every bit agrees, or is masked, or is ignored.
// Assumes all four inputs share the same bit positions.
module canaf_match #(
    parameter int W = 16
) (
    input  logic [W-1:0] field,
    input  logic [W-1:0] code,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] ign,
    output logic         hit
);
    // reduce the per-bit agreement
    always_comb hit = &(~(field ^ code) | mask | ign);
endmodule

// File: rtl/can_accept_filter.sv
// Acceptance filter top: configuration registers, field mapping,
// a single wide filter and two half-width filters, and a registered verdict.
// Assumes frm_valid is a one-cycle strobe with the header fields stable in it.
module can_accept_filter
    import can_accept_filter_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int NREG   = 4,
    parameter int SEL_W  = 4,
    localparam int VEC_W  = BYTE_W * NREG,
    localparam int HALF_W = VEC_W / 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctl_reset_mode,
    input  logic                cfg_we,
    input  logic [SEL_W-1:0]    cfg_sel,
    input  logic [BYTE_W-1:0]   cfg_wdata,
    input  logic                frm_valid,
    input  logic                frm_ext,
    input  logic                frm_rtr,
    input  logic [EXT_ID_W-1:0] frm_id,
    input  logic [DLC_W-1:0]    frm_dlc,
    input  logic [7:0]          frm_data0,
    input  logic [7:0]          frm_data1,
    output logic                accept_vld,
    output logic                accept
);
    logic [VEC_W-1:0]  code_vec, mask_vec, one_field, one_ign;
    logic [HALF_W-1:0] a_field, a_ign, b_field, b_ign;
    logic              single_mode, hit_one, hit_a, hit_b, verdict;
    filt_mode_e        mode;

    canaf_cfg_regs #(.BYTE_W(BYTE_W), .NREG(NREG), .SEL_W(SEL_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .ctl_reset_mode(ctl_reset_mode),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .code_vec(code_vec), .mask_vec(mask_vec), .single_mode(single_mode)
    );

    canaf_layout u_layout (
        .frm_ext(frm_ext), .frm_rtr(frm_rtr), .frm_id(frm_id), .frm_dlc(frm_dlc),
        .frm_data0(frm_data0), .frm_data1(frm_data1),
        .one_field(one_field), .one_ign(one_ign),
        .a_field(a_field), .a_ign(a_ign), .b_field(b_field), .b_ign(b_ign)
    );

    canaf_match #(.W(VEC_W)) u_one (
        .field(one_field), .code(code_vec), .mask(mask_vec), .ign(one_ign), .hit(hit_one)
    );
    canaf_match #(.W(HALF_W)) u_fa (
        .field(a_field), .code(code_vec[VEC_W-1 -: HALF_W]),
        .mask(mask_vec[VEC_W-1 -: HALF_W]), .ign(a_ign), .hit(hit_a)
    );
    canaf_match #(.W(HALF_W)) u_fb (
        .field(b_field), .code(code_vec[HALF_W-1:0]),
        .mask(mask_vec[HALF_W-1:0]), .ign(b_ign), .hit(hit_b)
    );

    assign mode = filt_mode_e'(single_mode);

    // choose the verdict for the selected filter mode
    always_comb begin
        case (mode)
            FILT_SINGLE: verdict = hit_one;
            default:     verdict = hit_a || hit_b;
        endcase
    end

    // register the verdict one cycle after the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            accept_vld <= 1'b0;
            accept     <= 1'b0;
        end else begin
            accept_vld <= frm_valid;
            if (frm_valid) accept <= verdict;
        end
    end

    assert_vld_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |=> accept_vld);
    assert_vld_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_valid |=> !accept_vld);
    assert_dual_either_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && !single_mode && (hit_a || hit_b)) |=> accept);
    assert_open_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && single_mode && (&mask_vec)) |=> accept);
    assert_single_reject_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && single_mode && !hit_one) |=> !accept);
endmodule

// File: tb/can_accept_filter_test.sv
module can_accept_filter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_reset_mode = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_sel = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        frm_valid = 1'b0, frm_ext = 1'b0, frm_rtr = 1'b0;
    logic [28:0] frm_id = '0;
    logic [3:0]  frm_dlc = '0;
    logic [7:0]  frm_data0 = '0, frm_data1 = '0;
    logic        accept_vld, accept;
    int          n_checks = 0, n_fail = 0, cycles = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    can_accept_filter uut (
        .clk(clk), .rst_n(rst_n), .ctl_reset_mode(ctl_reset_mode),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .frm_valid(frm_valid), .frm_ext(frm_ext), .frm_rtr(frm_rtr),
        .frm_id(frm_id), .frm_dlc(frm_dlc), .frm_data0(frm_data0),
        .frm_data1(frm_data1), .accept_vld(accept_vld), .accept(accept)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] sel, input logic [7:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic setup(input logic [31:0] codes, input logic [31:0] masks, input logic single);
        ctl_reset_mode = 1'b1;
        for (int i = 0; i < 4; i++) begin
            wr(4'(i), codes[31 - 8*i -: 8]);
            wr(4'(4 + i), masks[31 - 8*i -: 8]);
        end
        wr(4'd8, {7'd0, single});
        ctl_reset_mode = 1'b0;
    endtask

    // strobe one frame and check the verdict one cycle later
    task automatic frame(input string req, input logic ext, input logic rtr,
                         input logic [28:0] id, input logic [3:0] dlc,
                         input logic [7:0] d0, input logic [7:0] d1, input logic exp);
        @(negedge clk);
        frm_valid = 1'b1; frm_ext = ext; frm_rtr = rtr; frm_id = id;
        frm_dlc = dlc; frm_data0 = d0; frm_data1 = d1;
        @(negedge clk);
        frm_valid = 1'b0;
        check({req, " vld"}, accept_vld, 1'b1);
        check(req, accept, exp);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 vld low in reset", accept_vld, 1'b0);
        rst_n = 1'b1;
        frame("R1 open std", 1'b0, 1'b0, 29'h5A3, 4'd2, 8'h01, 8'h02, 1'b1);
        frame("R1 open ext", 1'b1, 1'b1, 29'h1ABCDEF0, 4'd0, 8'h00, 8'h00, 1'b1);
        @(negedge clk);
        check("R2 vld single pulse", accept_vld, 1'b0);
        check("R2 verdict held", accept, 1'b1);
    endtask

    task automatic t_single_std();
        setup(32'hB4_60_11_22, 32'h0, 1'b1);
        frame("R5 std match", 1'b0, 1'b0, 29'h5A3, 4'd2, 8'h11, 8'h22, 1'b1);
        frame("R5 data1 mismatch", 1'b0, 1'b0, 29'h5A3, 4'd2, 8'h11, 8'h23, 1'b0);
        frame("R5 id bit0 mismatch", 1'b0, 1'b0, 29'h5A2, 4'd2, 8'h11, 8'h22, 1'b0);
        frame("R5 id bit3 mismatch", 1'b0, 1'b0, 29'h5AB, 4'd2, 8'h11, 8'h22, 1'b0);
        frame("R10 dlc1 skips data1", 1'b0, 1'b0, 29'h5A3, 4'd1, 8'h11, 8'h99, 1'b1);
        frame("R10 dlc0 skips data0", 1'b0, 1'b0, 29'h5A3, 4'd0, 8'h77, 8'h99, 1'b1);
        frame("R5 rtr mismatch", 1'b0, 1'b1, 29'h5A3, 4'd2, 8'h11, 8'h22, 1'b0);
        setup(32'h70_7F_11_22, 32'h0, 1'b1);   // RTR set, low nibble junk
        frame("R10 remote skips data", 1'b0, 1'b1, 29'h5A3, 4'd8, 8'h55, 8'h66, 1'b0);
    endtask

    task automatic t_single_std_b();
        setup(32'hB4_7F_11_22, 32'h0, 1'b1);
        frame("R10 R11 remote and unused nibble", 1'b0, 1'b1, 29'h5A3, 4'd8, 8'h55, 8'h66, 1'b1);
        setup(32'hB4_60_11_22, 32'h0000_00FF, 1'b1);
        frame("R3 masked data1", 1'b0, 1'b0, 29'h5A3, 4'd2, 8'h11, 8'hEE, 1'b1);
    endtask

    task automatic t_single_ext();
        setup(32'h91_A2_B3_C3, 32'h0, 1'b1);
        frame("R6 R11 ext match", 1'b1, 1'b0, 29'h12345678, 4'd8, 8'h00, 8'h00, 1'b1);
        frame("R6 id0 mismatch", 1'b1, 1'b0, 29'h12345679, 4'd8, 8'h00, 8'h00, 1'b0);
        frame("R6 id28 mismatch", 1'b1, 1'b0, 29'h02345678, 4'd8, 8'h00, 8'h00, 1'b0);
        frame("R6 rtr mismatch", 1'b1, 1'b1, 29'h12345678, 4'd0, 8'h00, 8'h00, 1'b0);
        setup(32'h91_A2_B3_C0, 32'h0000_0008, 1'b1);
        frame("R3 masked id0", 1'b1, 1'b0, 29'h12345679, 4'd8, 8'h00, 8'h00, 1'b1);
    endtask

    task automatic t_dual_std();
        setup(32'hB4_69_24_6F, 32'h0, 1'b0);
        frame("R7 filter A", 1'b0, 1'b0, 29'h5A3, 4'd1, 8'h9C, 8'h00, 1'b1);
        frame("R7 R9 filter B", 1'b0, 1'b0, 29'h123, 4'd0, 8'h00, 8'h00, 1'b1);
        frame("R7 neither", 1'b0, 1'b0, 29'h124, 4'd0, 8'h00, 8'h00, 1'b0);
        frame("R7 data nibble mismatch", 1'b0, 1'b0, 29'h5A3, 4'd1, 8'h8C, 8'h00, 1'b0);
        frame("R10 dual dlc0 skips nibble", 1'b0, 1'b0, 29'h5A3, 4'd0, 8'h8C, 8'h00, 1'b1);
    endtask

    task automatic t_dual_ext();
        setup(32'h91_A2_00_00, 32'h0, 1'b0);
        frame("R8 filter A", 1'b1, 1'b0, 29'h12345678, 4'd0, 8'h00, 8'h00, 1'b1);
        frame("R8 R9 filter B", 1'b1, 1'b1, 29'h00000001, 4'd0, 8'h00, 8'h00, 1'b1);
        frame("R8 id13 mismatch", 1'b1, 1'b0, 29'h00002000, 4'd0, 8'h00, 8'h00, 1'b0);
    endtask

    task automatic t_lock();
        ctl_reset_mode = 1'b0;
        wr(4'd0, 8'h00);
        wr(4'd6, 8'hFF);
        wr(4'd8, 8'h01);
        frame("R4 code write ignored", 1'b1, 1'b0, 29'h12345678, 4'd0, 8'h00, 8'h00, 1'b1);
        frame("R4 mask and mode ignored", 1'b1, 1'b0, 29'h00002000, 4'd0, 8'h00, 8'h00, 1'b0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_single_std();
        t_single_std_b();
        t_single_ext();
        t_dual_std();
        t_dual_ext();
        t_lock();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule